// File: doc/BRIEF.md
# Compact 8-bit Instruction Core

This block is a small single-issue processor core with an 8-bit datapath. Each cycle it presents a word address to a program ROM and takes back a 16-bit instruction word from the same cycle. It runs a narrow instruction subset:

- do nothing;
- copy one register into another;
- load a constant into one of the upper sixteen registers;
- exchange the two nibbles of a register;
- set or clear any single status flag;
- jump relative to the program counter.

The architectural state is thirty-two 8-bit general registers, an 8-bit status register, the program counter and an execution cycle counter. All of them are brought out on observation ports so that a surrounding harness can follow the program as it runs.

Operand fields are packed into the instruction word in a compact, non-contiguous layout. Program addresses wrap through a configurable mask. Any word that does not match a supported pattern latches a sticky illegal-instruction flag and freezes the core until the next reset.

The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the first instruction executes on the third rising clock edge after the reset input rises.

Top module: `tiny8_core`

## Requirements
- R1: While reset is applied, and after it, the PC, all 32 registers, the status register and the cycle counter read 0, and the illegal flag is low.
- R2: The all-zero word executes as a no-op: only the PC advances by one word, and the cycle counter advances by one.
- R3: A word with bits 15:10 equal to 001011 copies register {bit9, bits3:0} into register bits8:4.
- R4: A word with bits 15:12 equal to 1110 loads register 16+bits7:4 with the constant {bits11:8, bits3:0}.
- R5: A word with bits 15:9 equal to 1001010 and bits 3:0 equal to 0010 swaps the high and low nibbles of register bits8:4.
- R6: A word with bits 15:7 equal to 100101000 and bits 3:0 equal to 1000 sets status bit n, where n is bits6:4. A word with bits 15:7 equal to 100101001 and bits 3:0 equal to 1000 clears status bit n. The bit order from 0 to 7 is C, Z, N, V, S, H, T, I.
- R7: A word with bits 15:12 equal to 1100 jumps to (PC + 1 + sign-extended bits11:0) AND the PC mask, counted in words. In byte terms this is the jump's own address plus 2 plus twice the offset.
- R8: Each non-jump instruction takes one cycle and adds 1 to the cycle counter. A jump takes two cycles and adds 2.
- R9: After a non-jump instruction the PC becomes (PC + 1) AND the PC mask, so execution wraps within the masked space.
- R10: Any other word sets a sticky illegal flag on the next edge. From then until reset the PC, registers, status register and cycle counter hold their values.
- R11: The ROM address output always equals the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| rom_addr_o | output | PC_W | Word address of the instruction being fetched |
| rom_data_i | input | 16 | Instruction word returned for rom_addr_o in the same cycle |
| pc_o | output | PC_W | Program counter (word address) |
| regs_o | output | NREG*XLEN | All general registers; register r is at bits r*8+7:r*8 |
| status_o | output | 8 | Status register |
| cycles_o | output | CYC_W | Executed-cycle counter |
| illegal_o | output | 1 | Sticky illegal-instruction flag |

## Verification
Every supported instruction commits its register, flag, PC and counter updates on the rising edge that ends its cycle. A jump also needs one bubble edge before the next fetched instruction is used. The bench keeps a reference model that steps one instruction at a time. For each instruction it waits one rising edge, or two for a jump, and compares the full state at the falling edge that follows. The illegal flag is due one edge after the bad word is presented. The bench samples it there and again several edges later, to confirm that the core stays frozen.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

  localparam int IW_W = 16;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_MOV,
    OP_LDI,
    OP_SWAP,
    OP_FSET,
    OP_FCLR,
    OP_JMP,
    OP_BAD
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [4:0] rd;
    logic [4:0] rs;
    logic [7:0] imm;
    logic [2:0] fidx;
    logic [11:0] off;
  } dec_t;

endpackage

// File: rtl/tiny8_rst_sync.sv
module tiny8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/tiny8_decode.sv
module tiny8_decode
  import tiny8_pkg::*;
(
  input  logic [IW_W-1:0] iw,
  output dec_t            dec
);

  always_comb begin
    dec      = '0;
    dec.op   = OP_BAD;
    dec.rd   = iw[8:4];
    dec.rs   = iw[8:4];
    dec.imm  = {iw[11:8], iw[3:0]};
    dec.fidx = iw[6:4];
    dec.off  = iw[11:0];

    case (iw[15:12])
      4'h0: begin
        if (iw == '0) dec.op = OP_NOP;
      end

      4'h2: begin
        if (iw[11:10] == 2'b11) begin
          dec.op = OP_MOV;
          dec.rs = {iw[9], iw[3:0]};
        end
      end

      4'h9: begin
        if (iw[11:9] == 3'b010 && iw[3:0] == 4'h2) begin
          dec.op = OP_SWAP;
        end else if (iw[11:7] == 5'b01000 && iw[3:0] == 4'h8) begin
          dec.op = OP_FSET;
        end else if (iw[11:7] == 5'b01001 && iw[3:0] == 4'h8) begin
          dec.op = OP_FCLR;
        end
      end

      4'hC: dec.op = OP_JMP;

      4'hE: begin
        dec.op = OP_LDI;
        dec.rd = {1'b1, iw[7:4]};
      end

      default: dec.op = OP_BAD;
    endcase
  end

endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
  parameter int NREG = 32,
  parameter int XLEN = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [XLEN-1:0]      wdata,
  input  logic [IDX_W-1:0]     ridx,
  output logic [XLEN-1:0]      rdata,
  output logic [NREG*XLEN-1:0] flat
);

  logic [NREG-1:0] we_vec;

  always_comb begin
    we_vec = '0;
    if (we) we_vec[widx] = 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (we_vec[g]) q <= wdata;
    end

    assign flat[g*XLEN +: XLEN] = q;
  end

  assign rdata = flat[ridx*XLEN +: XLEN];

  // R3
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> flat[$past(widx)*XLEN +: XLEN] == $past(wdata));

endmodule

// File: rtl/tiny8_ctrl.sv
module tiny8_ctrl
  import tiny8_pkg::*;
#(
  parameter int               PC_W    = 12,
  parameter logic [PC_W-1:0]  PC_MASK = '1,
  parameter int               CYC_W   = 32,
  parameter int               XLEN    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dec_t             dec,
  input  logic [XLEN-1:0]  rdata,
  output logic [4:0]       ridx,
  output logic             we,
  output logic [4:0]       widx,
  output logic [XLEN-1:0]  wdata,
  output logic [PC_W-1:0]  pc_q,
  output logic [7:0]       status_q,
  output logic [CYC_W-1:0] cyc_q,
  output logic             ill_q
);

  localparam int AW = 32;

  logic             jw_q;
  logic [PC_W-1:0]  pc_d;
  logic [7:0]       status_d;
  logic [CYC_W-1:0] cyc_d;
  logic             ill_d, jw_d;
  logic             pc_en, st_en, cyc_en, ill_en, jw_en;
  logic             exec;
  logic [AW-1:0]    seq_w, tgt_w;

  assign exec  = !ill_q && !jw_q;
  assign ridx  = dec.rs;
  assign seq_w = AW'(pc_q) + 1;
  assign tgt_w = seq_w + {{(AW-12){dec.off[11]}}, dec.off};

  always_comb begin
    pc_d     = pc_q;
    status_d = status_q;
    cyc_d    = cyc_q + 1'b1;
    ill_d    = ill_q;
    jw_d     = 1'b0;
    pc_en    = 1'b0;
    st_en    = 1'b0;
    cyc_en   = 1'b0;
    ill_en   = 1'b0;
    jw_en    = 1'b0;
    we       = 1'b0;
    widx     = dec.rd;
    wdata    = dec.imm;

    if (!ill_q && jw_q) begin
      cyc_en = 1'b1;
      jw_en  = 1'b1;
    end else if (exec) begin
      if (dec.op == OP_BAD) begin
        ill_d  = 1'b1;
        ill_en = 1'b1;
      end else begin
        cyc_en = 1'b1;
        pc_en  = 1'b1;
        pc_d   = seq_w[PC_W-1:0] & PC_MASK;
        case (dec.op)
          OP_MOV: begin
            we    = 1'b1;
            wdata = rdata;
          end
          OP_LDI: we = 1'b1;
          OP_SWAP: begin
            we    = 1'b1;
            wdata = {rdata[3:0], rdata[7:4]};
          end
          OP_FSET: begin
            st_en              = 1'b1;
            status_d[dec.fidx] = 1'b1;
          end
          OP_FCLR: begin
            st_en              = 1'b1;
            status_d[dec.fidx] = 1'b0;
          end
          OP_JMP: begin
            pc_d  = tgt_w[PC_W-1:0] & PC_MASK;
            jw_d  = 1'b1;
            jw_en = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      status_q <= '0;
      cyc_q    <= '0;
      ill_q    <= 1'b0;
      jw_q     <= 1'b0;
    end else begin
      if (pc_en)  pc_q     <= pc_d;
      if (st_en)  status_q <= status_d;
      if (cyc_en) cyc_q    <= cyc_d;
      if (ill_en) ill_q    <= ill_d;
      if (jw_en)  jw_q     <= jw_d;
    end
  end

  // R10
  ill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> ill_q);

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> ($stable(pc_q) && $stable(cyc_q) && $stable(status_q)));

  // R8
  jmp_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jw_q |=> !jw_q);

  // R8
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ill_q && (jw_q || dec.op != OP_BAD)) |=> cyc_q == $past(cyc_q) + 1'b1);

  // R6
  fset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && dec.op == OP_FSET) |=> status_q[$past(dec.fidx)]);

  // R6
  fclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && dec.op == OP_FCLR) |=> !status_q[$past(dec.fidx)]);

  // R9
  pc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q & ~PC_MASK) == '0);

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter int               PC_W    = 12,
  parameter logic [PC_W-1:0]  PC_MASK = '1,
  parameter int               CYC_W   = 32,
  parameter int               NREG    = 32,
  parameter int               XLEN    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [PC_W-1:0]      rom_addr_o,
  input  logic [IW_W-1:0]      rom_data_i,
  output logic [PC_W-1:0]      pc_o,
  output logic [NREG*XLEN-1:0] regs_o,
  output logic [7:0]           status_o,
  output logic [CYC_W-1:0]     cycles_o,
  output logic                 illegal_o
);

  logic            rst_ni;
  dec_t            dec;
  logic            we;
  logic [4:0]      widx, ridx;
  logic [XLEN-1:0] wdata, rdata;
  logic [PC_W-1:0] pc_q;

  tiny8_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  tiny8_decode u_dec (
    .iw  (rom_data_i),
    .dec (dec)
  );

  tiny8_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_ni),
    .we    (we),
    .widx  (widx),
    .wdata (wdata),
    .ridx  (ridx),
    .rdata (rdata),
    .flat  (regs_o)
  );

  tiny8_ctrl #(.PC_W(PC_W), .PC_MASK(PC_MASK), .CYC_W(CYC_W), .XLEN(XLEN)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_ni),
    .dec      (dec),
    .rdata    (rdata),
    .ridx     (ridx),
    .we       (we),
    .widx     (widx),
    .wdata    (wdata),
    .pc_q     (pc_q),
    .status_q (status_o),
    .cyc_q    (cycles_o),
    .ill_q    (illegal_o)
  );

  assign pc_o       = pc_q;
  assign rom_addr_o = pc_q;

  // R11
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rom_addr_o == pc_o);

endmodule

// File: tb/tiny8_core_test.sv
`timescale 1ns/1ps
module tiny8_core_test;

  localparam int              PC_W  = 8;
  localparam logic [7:0]      MASK  = 8'h7F;
  localparam int              CYC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      rom_addr;
  logic [15:0]     rom_data;
  logic [7:0]      pc;
  logic [255:0]    regs;
  logic [7:0]      status;
  logic [31:0]     cycles;
  logic            illegal;

  logic [15:0] rom [256];
  assign rom_data = rom[rom_addr];

  always #4 clk = ~clk;

  tiny8_core #(.PC_W(PC_W), .PC_MASK(MASK), .CYC_W(CYC_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rom_addr_o (rom_addr),
    .rom_data_i (rom_data),
    .pc_o       (pc),
    .regs_o     (regs),
    .status_o   (status),
    .cycles_o   (cycles),
    .illegal_o  (illegal)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  m_r [32];
  logic [7:0]  m_pc;
  logic [7:0]  m_st;
  logic [31:0] m_cyc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] e_mov(int d, int s);
    logic [4:0] s5 = 5'(s);
    return 16'h2C00 | (16'(s5[4]) << 9) | (16'(d) << 4) | 16'(s5[3:0]);
  endfunction
  function automatic logic [15:0] e_ldi(int d16, logic [7:0] k);
    return 16'hE000 | (16'(k[7:4]) << 8) | (16'(d16) << 4) | 16'(k[3:0]);
  endfunction
  function automatic logic [15:0] e_swap(int d);
    return 16'h9402 | (16'(d) << 4);
  endfunction
  function automatic logic [15:0] e_fset(int i);
    return 16'h9408 | (16'(i) << 4);
  endfunction
  function automatic logic [15:0] e_fclr(int i);
    return 16'h9488 | (16'(i) << 4);
  endfunction
  function automatic logic [15:0] e_jmp(int off);
    return 16'hC000 | 16'(off & 12'hFFF);
  endfunction

  task automatic compare_all(input string req);
    int bad = -1;
    check(pc == m_pc, req, "pc", 32'(pc), 32'(m_pc));
    check(status == m_st, req, "status", 32'(status), 32'(m_st));
    check(cycles == m_cyc, "R8", "cycles", cycles, m_cyc);
    check(illegal == 1'b0, req, "illegal", 32'(illegal), 0);
    for (int r = 0; r < 32; r++)
      if (bad < 0 && regs[r*8 +: 8] != m_r[r]) bad = r;
    if (bad < 0) check(1'b1, req, "regs", 0, 0);
    else check(1'b0, req, $sformatf("r%0d", bad), 32'(regs[bad*8 +: 8]), 32'(m_r[bad]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int r = 0; r < 32; r++) m_r[r] = 8'h00;
    m_pc = 0; m_st = 0; m_cyc = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  // Reference model: one instruction per call, then compare.
  task automatic step();
    logic [15:0] w = rom[m_pc];
    int          n = 1;
    string       req;
    logic [7:0]  v;
    int          d;
    int          s;
    logic [31:0] t;
    if (w == 16'h0000) begin
      req = "R2";
      m_pc = (m_pc + 1) & MASK;
    end else if (w[15:10] == 6'b001011) begin
      req = "R3";
      d = int'(w[8:4]);
      s = int'({w[9], w[3:0]});
      m_r[d] = m_r[s];
      m_pc = (m_pc + 1) & MASK;
    end else if (w[15:12] == 4'hE) begin
      req = "R4";
      m_r[16 + int'(w[7:4])] = {w[11:8], w[3:0]};
      m_pc = (m_pc + 1) & MASK;
    end else if (w[15:9] == 7'b1001010 && w[3:0] == 4'h2) begin
      req = "R5";
      v = m_r[w[8:4]];
      m_r[w[8:4]] = {v[3:0], v[7:4]};
      m_pc = (m_pc + 1) & MASK;
    end else if (w[15:7] == 9'b100101000 && w[3:0] == 4'h8) begin
      req = "R6";
      m_st[w[6:4]] = 1'b1;
      m_pc = (m_pc + 1) & MASK;
    end else if (w[15:7] == 9'b100101001 && w[3:0] == 4'h8) begin
      req = "R6";
      m_st[w[6:4]] = 1'b0;
      m_pc = (m_pc + 1) & MASK;
    end else if (w[15:12] == 4'hC) begin
      req = "R7";
      t = 32'(m_pc) + 1 + {{20{w[11]}}, w[11:0]};
      m_pc = t[7:0] & MASK;
      n = 2;
    end else begin
      req = "R10";
      $display("FAIL R10 model reached illegal word: actual %0h expected legal", w);
      n_fail++;
    end
    m_cyc = m_cyc + 32'(n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    if (m_pc == ((m_pc - 1) & MASK) + 1 && req != "R7") req = req;
    compare_all(req);
    check(rom_addr == pc, "R11", "rom_addr", 32'(rom_addr), 32'(pc));
  endtask

  task automatic build_main();
    for (int a = 0; a < 256; a++) rom[a] = (a < 128) ? 16'h0000 : 16'h0001;
    for (int i = 0; i < 16; i++)  rom[i]      = e_ldi(i, 8'(i * 37 + 5));
    for (int i = 0; i < 32; i++)  rom[16 + i] = e_mov(i, (i * 7 + 16) % 32);
    for (int i = 0; i < 32; i++)  rom[48 + i] = e_swap(i);
    for (int i = 0; i < 8; i++)   rom[80 + i] = e_fset(i);
    for (int i = 0; i < 4; i++)   rom[88 + i] = e_fclr(2 * i);
    rom[92] = e_jmp(5);
    for (int a = 93; a < 98; a++) rom[a] = 16'h0001;
    rom[98]  = e_jmp(2);
    rom[99]  = 16'h0001;
    rom[100] = 16'h1000;
    rom[101] = e_jmp(-110);
    rom[120] = e_ldi(15, 8'hA5);
    rom[121] = e_jmp(-20);
    rom[102] = e_mov(0, 31);
    rom[103] = e_swap(0);
    rom[104] = e_fset(7);
    rom[105] = e_fclr(7);
    rom[106] = e_mov(31, 0);
    rom[107] = e_jmp(15);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] bad_words [6];
    bad_words[0] = 16'h0001; bad_words[1] = 16'h1000; bad_words[2] = 16'h2800;
    bad_words[3] = 16'h9400; bad_words[4] = 16'h9409; bad_words[5] = 16'hF000;

    build_main();
    do_reset();
    // R1: state during reset
    compare_all("R1");
    release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    // R1: state just after release, before the first execute edge
    compare_all("R1");
    for (int i = 0; i < 300; i++) step();

    // R10: one run per illegal encoding
    for (int b = 0; b < 6; b++) begin
      for (int a = 0; a < 256; a++) rom[a] = 16'h0000;
      rom[0] = e_ldi(4, 8'h3C);
      rom[1] = e_fset(1);
      rom[2] = bad_words[b];
      rom[3] = e_ldi(4, 8'hFF);
      do_reset();
      release_reset();
      @(negedge clk);
      step();
      step();
      @(posedge clk);
      @(negedge clk);
      check(illegal == 1'b1, "R10", "illegal set", 32'(illegal), 1);
      check(pc == 8'd2, "R10", "pc held", 32'(pc), 2);
      repeat (6) @(posedge clk);
      @(negedge clk);
      check(illegal == 1'b1, "R10", "illegal sticky", 32'(illegal), 1);
      check(pc == 8'd2, "R10", "pc frozen", 32'(pc), 2);
      check(cycles == 32'd2, "R10", "cycles frozen", cycles, 2);
      check(status == 8'h02, "R10", "status frozen", 32'(status), 2);
      check(regs[4*8 +: 8] == 8'h00 && regs[20*8 +: 8] == 8'h3C, "R10", "regs frozen",
            32'(regs[20*8 +: 8]), 32'h3C);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule